// File: doc/BRIEF.md
# Flash Write-Status Read Responder

This block decides what a read returns from a multi-bank NOR flash while an embedded program or erase is running. For each read it chooses between the plain array word and a status word. In a status word three bits carry progress information: a polling bit (bit 7) and two toggle bits (bits 6 and 2). All other bits of a status word carry the array input. The block also drives an active-low ready/busy line.

The command decoder presents the kind of operation, the busy bank and a start pulse once the last write strobe of the sequence has been taken. That is the 4th strobe for a program and the 6th for an erase, so status is reported from that point on. During an erase suspend it also presents the suspended sector. The flash array is replaced by a data input that the caller fills for each read. A read is taken on a clock edge with `rd_en` high, and the result appears on `rd_data` after that edge.

Top module: `flash_stat_rpt`

## Requirements
- R1: While `rst_n` is low, `rd_data` is all zeros and both toggle states are 0.
- R2: `rb_n` is 0 while `op_kind` is 1 (program), or while `op_kind` is 2 (erase) with `sus_en` low. It is 1 when `op_kind` is 0 or 3 (idle), and 1 during an erase suspend with no program running.
- R3: A read that is neither in the suspended sector nor in the bank of an active operation returns `arr_data` unchanged. The bank is the top `BANK_W` bits of `rd_sect`.
- R4: A read into the bank of a running program returns the inverse of `wr_poll_bit` in bit 7. Every bit other than 7, 6 and 2 comes from `arr_data`.
- R5: Status reads during a program, or during an unsuspended erase, return the bit-6 toggle state in bit 6 and then invert that state. Consecutive such reads therefore alternate, starting from 0.
- R6: A read into the bank of an unsuspended erase returns 0 in bit 7. It returns the bit-2 toggle state in bit 2 and then inverts it.
- R7: Program status reads leave the bit-2 toggle state unchanged and return it in bit 2.
- R8: With `sus_en` high, a read whose `rd_sect` equals `sus_sector` returns 1 in bits 7 and 6. It returns the bit-2 toggle state in bit 2, inverts that state, and leaves the bit-6 state unchanged.
- R9: During an erase suspend with no program running, a read of any sector other than the suspended one returns array data, even within the erase bank.
- R10: A program started during an erase suspend reports program status for reads into its bank. A read of the suspended sector still follows R8.
- R11: An `op_start` pulse clears both toggle states to 0. A read in the same cycle still uses the states held before the clear.
- R12: With `rd_en` low, `rd_data` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one read per cycle |
| rd_sect | input | SECT_W | Sector index of the read address; the top BANK_W bits are the bank |
| arr_data | input | DATA_W | Array word at the read address |
| op_start | input | 1 | Pulse when a new program or erase begins |
| op_kind | input | 2 | 0 idle, 1 program, 2 erase, 3 idle |
| op_bank | input | BANK_W | Bank of the running operation |
| wr_poll_bit | input | 1 | Bit 7 of the word being programmed |
| sus_en | input | 1 | Erase is suspended |
| sus_sector | input | SECT_W | Sector whose erase is suspended |
| rd_data | output | DATA_W | Registered read word |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The bench sweeps every sector for each operation kind and each busy bank. It uses back-to-back reads, so a toggle bit that fails to flip, or flips twice, shows up as a repeated or skipped value. If a bank compare used the wrong address bits, status would appear in the wrong bank, or array data would appear in the busy one.

The suspend sweeps target three mistakes. One is letting the suspended erase still claim its whole bank. Another is advancing the bit-6 state on suspended-sector reads. The third is letting a program in the same bank hide the suspended sector. A clear-then-read check catches a design that misses the reset of the toggle states on a new operation. A hold check with changing inputs catches a design whose output register loads without a read.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
   typedef enum logic [1:0] {
      OPK_IDLE  = 2'd0,
      OPK_PROG  = 2'd1,
      OPK_ERASE = 2'd2,
      OPK_RSVD  = 2'd3
   } opk_e;

   typedef enum logic [1:0] {
      RSP_ARRAY = 2'd0,
      RSP_PROG  = 2'd1,
      RSP_ERASE = 2'd2,
      RSP_SUSP  = 2'd3
   } rsp_e;

   localparam int POLL_POS  = 7;
   localparam int TGLA_POS  = 6;
   localparam int TGLB_POS  = 2;
   localparam int TGL_A     = 0;
   localparam int TGL_B     = 1;
   localparam int NUM_TGL   = 2;
endpackage

// File: rtl/fsr_region_decode.sv
`timescale 1ns/1ps
module fsr_region_decode #(
   parameter int BANK_W = 2,
   parameter int SECT_W = 4
) (
   input  logic [SECT_W-1:0] rd_sect,
   input  logic [BANK_W-1:0] op_bank,
   input  logic [SECT_W-1:0] sus_sector,
   output logic              bank_hit,
   output logic              sect_hit
);
   localparam int SUB_W = SECT_W - BANK_W;

   logic [BANK_W-1:0] rd_bank;
   assign rd_bank  = rd_sect[SECT_W-1 -: BANK_W];
   assign bank_hit = (rd_bank == op_bank);

   generate
      if (SUB_W == 0) begin : g_one_per_bank
         assign sect_hit = (rd_bank == sus_sector[SECT_W-1 -: BANK_W]);
      end else begin : g_many_per_bank
         logic bank_eq, sub_eq;
         assign bank_eq  = (rd_bank == sus_sector[SECT_W-1 -: BANK_W]);
         assign sub_eq   = (rd_sect[SUB_W-1:0] == sus_sector[SUB_W-1:0]);
         assign sect_hit = bank_eq && sub_eq;
      end
   endgenerate
endmodule

// File: rtl/fsr_classify.sv
`timescale 1ns/1ps
module fsr_classify
   import fsr_pkg::*;
(
   input  logic                rd_en,
   input  opk_e                kind,
   input  logic                sus_en,
   input  logic                bank_hit,
   input  logic                sect_hit,
   output rsp_e                cls,
   output logic [NUM_TGL-1:0]  flip,
   output logic                busy_n
);
   logic prog_run, erase_run;

   assign prog_run  = (kind == OPK_PROG);
   assign erase_run = (kind == OPK_ERASE) && !sus_en;
   assign busy_n    = !(prog_run || erase_run);

   always_comb begin
      if (sus_en && sect_hit)
         cls = RSP_SUSP;
      else if (bank_hit && prog_run)
         cls = RSP_PROG;
      else if (bank_hit && erase_run)
         cls = RSP_ERASE;
      else
         cls = RSP_ARRAY;
   end

   always_comb begin
      flip = '0;
      if (rd_en) begin
         flip[TGL_A] = (cls == RSP_PROG) || (cls == RSP_ERASE);
         flip[TGL_B] = (cls == RSP_ERASE) || (cls == RSP_SUSP);
      end
   end
endmodule

// File: rtl/fsr_toggle_bank.sv
`timescale 1ns/1ps
module fsr_toggle_bank #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] flip,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_tgl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= 1'b0;
            else if (clr)
               q[i] <= 1'b0;
            else if (flip[i])
               q[i] <= ~q[i];
         end
      end
   endgenerate
endmodule

// File: rtl/fsr_word_build.sv
`timescale 1ns/1ps
module fsr_word_build
   import fsr_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  rsp_e               cls,
   input  logic [DATA_W-1:0]  arr_data,
   input  logic               poll_bit,
   input  logic [NUM_TGL-1:0] tgl,
   output logic [DATA_W-1:0]  rd_data
);
   logic [DATA_W-1:0] nxt;

   always_comb begin
      nxt = arr_data;
      unique case (cls)
         RSP_PROG: begin
            nxt[POLL_POS] = ~poll_bit;
            nxt[TGLA_POS] = tgl[TGL_A];
            nxt[TGLB_POS] = tgl[TGL_B];
         end
         RSP_ERASE: begin
            nxt[POLL_POS] = 1'b0;
            nxt[TGLA_POS] = tgl[TGL_A];
            nxt[TGLB_POS] = tgl[TGL_B];
         end
         RSP_SUSP: begin
            nxt[POLL_POS] = 1'b1;
            nxt[TGLA_POS] = 1'b1;
            nxt[TGLB_POS] = tgl[TGL_B];
         end
         default: nxt = arr_data;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= nxt;
   end
endmodule

// File: rtl/flash_stat_rpt.sv
`timescale 1ns/1ps
module flash_stat_rpt
   import fsr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BANK_W = 2,
   parameter int SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [SECT_W-1:0] rd_sect,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [BANK_W-1:0] op_bank,
   input  logic              wr_poll_bit,
   input  logic              sus_en,
   input  logic [SECT_W-1:0] sus_sector,
   output logic [DATA_W-1:0] rd_data,
   output logic              rb_n
);
   generate
      if (DATA_W < POLL_POS + 1) begin : g_bad_data_w
         $error("flash_stat_rpt: DATA_W must hold the status bits");
      end
      if (BANK_W < 1) begin : g_bad_bank_w
         $error("flash_stat_rpt: BANK_W must be at least 1");
      end
      if (SECT_W < BANK_W) begin : g_bad_sect_w
         $error("flash_stat_rpt: SECT_W must not be below BANK_W");
      end
   endgenerate

   logic               bank_hit, sect_hit;
   rsp_e               cls;
   logic [NUM_TGL-1:0] flip, tgl;
   opk_e               kind;

   assign kind = opk_e'(op_kind);

   fsr_region_decode #(.BANK_W(BANK_W), .SECT_W(SECT_W)) u_dec (
      .rd_sect    (rd_sect),
      .op_bank    (op_bank),
      .sus_sector (sus_sector),
      .bank_hit   (bank_hit),
      .sect_hit   (sect_hit)
   );

   fsr_classify u_cls (
      .rd_en    (rd_en),
      .kind     (kind),
      .sus_en   (sus_en),
      .bank_hit (bank_hit),
      .sect_hit (sect_hit),
      .cls      (cls),
      .flip     (flip),
      .busy_n   (rb_n)
   );

   fsr_toggle_bank #(.N(NUM_TGL)) u_tgl (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (op_start),
      .flip  (flip),
      .q     (tgl)
   );

   fsr_word_build #(.DATA_W(DATA_W)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .cls      (cls),
      .arr_data (arr_data),
      .poll_bit (wr_poll_bit),
      .tgl      (tgl),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/fsr_checker.sv
`timescale 1ns/1ps
module fsr_checker #(
   parameter int DATA_W = 16,
   parameter int BANK_W = 2,
   parameter int SECT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [SECT_W-1:0] rd_sect,
   input logic [DATA_W-1:0] arr_data,
   input logic              op_start,
   input logic [1:0]        op_kind,
   input logic [BANK_W-1:0] op_bank,
   input logic              wr_poll_bit,
   input logic              sus_en,
   input logic [SECT_W-1:0] sus_sector,
   input logic [DATA_W-1:0] rd_data,
   input logic              rb_n
);
   logic bh, in_susp, q_prog, q_erase, q_arr, prev_t6, prev_prog;

   assign bh      = (rd_sect[SECT_W-1 -: BANK_W] == op_bank);
   assign in_susp = sus_en && (rd_sect == sus_sector);
   assign q_prog  = rd_en && !in_susp && bh && (op_kind == 2'd1);
   assign q_erase = rd_en && !in_susp && bh && (op_kind == 2'd2) && !sus_en;
   assign q_arr   = rd_en && !in_susp && !q_prog && !q_erase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_t6   <= 1'b0;
         prev_prog <= 1'b0;
      end else begin
         prev_t6   <= (q_prog || q_erase) && !op_start;
         prev_prog <= q_prog && !op_start;
      end
   end

   p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> rd_data == '0);
   p_busy_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == 2'd1) |-> !rb_n);
   p_ready_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sus_en && op_kind != 2'd1) |-> rb_n);
   p_array_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_arr |=> rd_data == $past(arr_data));
   p_prog_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_prog |=> rd_data[7] == !$past(wr_poll_bit));
   p_dq6_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_prog || q_erase) && prev_t6) |=> rd_data[6] != $past(rd_data[6]));
   p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_erase |=> !rd_data[7]);
   p_prog_dq2_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_prog && prev_prog) |=> rd_data[2] == $past(rd_data[2]));
   p_susp_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_susp) |=> (rd_data[7] && rd_data[6]));
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

bind flash_stat_rpt fsr_checker #(
   .DATA_W(DATA_W), .BANK_W(BANK_W), .SECT_W(SECT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sect(rd_sect),
   .arr_data(arr_data), .op_start(op_start), .op_kind(op_kind),
   .op_bank(op_bank), .wr_poll_bit(wr_poll_bit), .sus_en(sus_en),
   .sus_sector(sus_sector), .rd_data(rd_data), .rb_n(rb_n)
);

// File: tb/flash_stat_rpt_tb.sv
`timescale 1ns/1ps
module flash_stat_rpt_tb;
   localparam int DW = 16, BW = 2, SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0;
   logic [SW-1:0] rd_sect = '0;
   logic [DW-1:0] arr_data = '0;
   logic          op_start = 1'b0;
   logic [1:0]    op_kind = 2'd0;
   logic [BW-1:0] op_bank = '0;
   logic          wr_poll_bit = 1'b0;
   logic          sus_en = 1'b0;
   logic [SW-1:0] sus_sector = '0;
   logic [DW-1:0] rd_data;
   logic          rb_n;

   int checks = 0, errors = 0, nrd = 0;
   logic m6 = 1'b0, m2 = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flash_stat_rpt #(.DATA_W(DW), .BANK_W(BW), .SECT_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sect(rd_sect),
      .arr_data(arr_data), .op_start(op_start), .op_kind(op_kind),
      .op_bank(op_bank), .wr_poll_bit(wr_poll_bit), .sus_en(sus_en),
      .sus_sector(sus_sector), .rd_data(rd_data), .rb_n(rb_n)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_rb(input string req);
      logic e;
      #1;
      e = !((op_kind == 2'd1) || (op_kind == 2'd2 && !sus_en));
      chk(rb_n == e, req, {15'd0, rb_n}, {15'd0, e});
   endtask

   task automatic start_op(input logic [1:0] k, input logic [BW-1:0] b);
      @(negedge clk);
      rd_en = 1'b0; op_kind = k; op_bank = b; op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0; m6 = 1'b0; m2 = 1'b0;
   endtask

   // one read per cycle; result checked just after the loading edge
   task automatic rd(input logic [SW-1:0] s);
      logic [DW-1:0] exp;
      string req;
      bit bh, sh;
      @(negedge clk);
      nrd++;
      rd_sect = s; rd_en = 1'b1;
      arr_data = 16'(s * 16'h1357 + nrd * 16'h0F1D);
      wr_poll_bit = nrd[1];
      bh = (s[SW-1 -: BW] == op_bank);
      sh = sus_en && (s == sus_sector);
      exp = arr_data;
      if (sh) begin
         exp[7] = 1'b1; exp[6] = 1'b1; exp[2] = m2; m2 = ~m2;
         req = (op_kind == 2'd1) ? "R10 suspended sector" : "R8 suspended sector";
      end else if (bh && op_kind == 2'd1) begin
         exp[7] = ~wr_poll_bit; exp[6] = m6; exp[2] = m2; m6 = ~m6;
         req = sus_en ? "R10 program in suspend" : "R4/R5/R7 program status";
      end else if (bh && op_kind == 2'd2 && !sus_en) begin
         exp[7] = 1'b0; exp[6] = m6; exp[2] = m2; m6 = ~m6; m2 = ~m2;
         req = "R6/R5 erase status";
      end else begin
         req = sus_en ? "R9 array in suspend" : "R3 array data";
      end
      @(posedge clk); #1;
      chk(rd_data == exp, req, rd_data, exp);
   endtask

   task automatic rd_stop();
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      logic [DW-1:0] held;
      #2;
      chk(rd_data == '0, "R1 reset word", rd_data, '0);
      repeat (3) @(posedge clk);
      #1 chk(rd_data == '0, "R1 reset word held", rd_data, '0);
      @(negedge clk); rst_n = 1'b1;
      check_rb("R2 idle ready");

      // idle and reserved kind: all sectors pass array data
      for (int s = 0; s < 16; s++) rd(4'(s));
      start_op(2'd3, 2'd2);
      check_rb("R2 reserved kind ready");
      for (int s = 0; s < 16; s++) rd(4'(s));
      rd_stop();

      // program and erase in every bank, every sector, two passes
      for (int k = 1; k <= 2; k++) begin
         for (int b = 0; b < 4; b++) begin
            start_op(2'(k), 2'(b));
            check_rb("R2 busy");
            for (int p = 0; p < 2; p++)
               for (int s = 0; s < 16; s++) rd(4'(s));
            for (int s = 0; s < 3; s++) rd(4'(b * 4 + 1));
            rd_stop();
         end
      end

      // R11: clear toggles on a new operation
      start_op(2'd2, 2'd0);
      rd(4'd0); rd(4'd1); rd(4'd2);
      start_op(2'd2, 2'd0);
      rd(4'd3);
      chk(rd_data[6] == 1'b0 && rd_data[2] == 1'b0, "R11 toggles cleared",
          rd_data, {rd_data[15:7], 1'b0, rd_data[5:3], 1'b0, rd_data[1:0]});
      rd_stop();

      // erase suspend in bank 1, sector 6
      start_op(2'd2, 2'd1);
      rd(4'd6); rd(4'd5);
      @(negedge clk); sus_en = 1'b1; sus_sector = 4'd6;
      check_rb("R2 suspend ready");
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 16; s++) rd(4'(s));
      for (int s = 0; s < 4; s++) rd(4'd6);
      rd_stop();

      // program during suspend: same bank, then another bank
      start_op(2'd1, 2'd1);
      check_rb("R2 program in suspend busy");
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 16; s++) rd(4'(s));
      rd(4'd6); rd(4'd7); rd(4'd6); rd(4'd4);
      rd_stop();
      start_op(2'd1, 2'd3);
      for (int s = 0; s < 16; s++) rd(4'(s));
      rd(4'd6); rd(4'd13); rd(4'd6);

      // R12: no read, inputs move, output holds
      rd_stop();
      @(posedge clk); #1 held = rd_data;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         arr_data = 16'(i * 16'h2F3B); rd_sect = 4'(i); op_kind = 2'(i);
         sus_en = i[0]; op_start = i[2];
         @(posedge clk); #1;
         chk(rd_data == held, "R12 hold without read", rd_data, held);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule